// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This block is the integer execute stage of a 32-bit load-store core. It takes an instruction that has already been split into fields: a 6-bit opcode, a 6-bit function code, a shift distance, the rs and rt register values, the rt and rd register indices and the 16-bit immediate. It then picks the second operand. That operand is either the rt register value or the immediate, and the immediate is widened in the way the instruction calls for. The stage computes one of the following: add, subtract, bitwise logic, signed or unsigned set-less-than, constant or variable shifts, or load-upper. The result, a write-enable hint and the chosen destination index are registered, so they appear one clock after the fields are applied.

The immediate is widened in one of three ways:
- Arithmetic immediates and the signed compare immediate sign-extend it.
- Logical immediates, the unsigned add immediate and the unsigned compare immediate zero-extend it.
- Load-upper places it in the upper half of the result.

Overflow traps, multiply/divide, memory access and branch resolution sit outside this stage.

Top module: `exu_int_alu`

## Requirements
- R1: With opcode 0, function codes 32 (add), 33 (addu), 34 (sub) and 35 (subu) produce rs+rt or rs-rt modulo 2^32. The signed and unsigned forms give identical results and never trap.
- R2: Opcode 8 (addi) adds the sign-extended immediate to rs, so an immediate of 0xFFFD adds -3. Opcode 9 (addiu) adds the zero-extended immediate.
- R3: Opcodes 12 (andi), 13 (ori) and 14 (xori) combine rs bitwise with the zero-extended immediate. For example, andi with 0xFFFF keeps only bits 15:0 of rs.
- R4: Opcode 15 (lui) yields the immediate in bits 31:16 and zeros in bits 15:0, whatever the value of rs.
- R5: With opcode 0, function codes 36, 37, 38 and 39 give rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt) across all 32 bits.
- R6: Function 42 (slt) and opcode 10 (slti) give 1 when rs is less than the second operand as signed numbers, else 0. Slti uses the sign-extended immediate. Function 43 (sltu) and opcode 11 (sltiu) compare as unsigned numbers, and sltiu uses the zero-extended immediate.
- R7: Function codes 0 (sll), 2 (srl) and 3 (sra) shift rt by the shamt field. Sll and srl fill with zeros, and sra fills with bit 31 of rt.
- R8: Function codes 4 (sllv), 6 (srlv) and 7 (srav) shift rt by bits 4:0 of rs, using the same fill rules as R7.
- R9: The destination is rd for opcode 0 and rt for opcodes 8 to 15. The write enable is low whenever that destination is register 0.
- R10: An opcode outside {0, 8..15}, or a function code outside the list above under opcode 0, gives result 0, write enable low and destination 0.
- R11: Result, write enable and destination are registered and change one clock after the inputs. While reset is low they hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Instruction opcode field |
| funct_i | input | 6 | Function field for register-register forms |
| shamt_i | input | 5 | Constant shift distance |
| rs_val_i | input | 32 | Value of register rs |
| rt_val_i | input | 32 | Value of register rt |
| imm_i | input | 16 | Immediate field |
| rt_idx_i | input | 5 | Index of register rt |
| rd_idx_i | input | 5 | Index of register rd |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Registered write-enable hint |
| dest_o | output | 5 | Registered destination index |

## Verification
The assertions check several properties on every cycle:
- Load-upper places the immediate high with a clear low half.
- Set-less-than results are only 0 or 1.
- Logical immediates leave the upper half as zero (andi) or as rs (ori).
- A zero destination never raises the write enable.
- Unsupported opcodes yield nothing.

Only the bench's sweeps can show the exact arithmetic values. These cover sign versus zero extension at the 0x7FFF/0x8000 boundary, signed versus unsigned ordering at 0x80000000, every shift distance 0 to 31 for each fill rule, and the register-0 case across every index. The reset value and the one-cycle latency are also shown only by the bench.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_ADDIU = 6'd9;
    localparam logic [5:0] OPC_SLTI  = 6'd10;
    localparam logic [5:0] OPC_SLTIU = 6'd11;
    localparam logic [5:0] OPC_ANDI  = 6'd12;
    localparam logic [5:0] OPC_ORI   = 6'd13;
    localparam logic [5:0] OPC_XORI  = 6'd14;
    localparam logic [5:0] OPC_LUI   = 6'd15;

    localparam logic [5:0] FN_SLL  = 6'd0;
    localparam logic [5:0] FN_SRL  = 6'd2;
    localparam logic [5:0] FN_SRA  = 6'd3;
    localparam logic [5:0] FN_SLLV = 6'd4;
    localparam logic [5:0] FN_SRLV = 6'd6;
    localparam logic [5:0] FN_SRAV = 6'd7;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_ADDU = 6'd33;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SUBU = 6'd35;
    localparam logic [5:0] FN_AND  = 6'd36;
    localparam logic [5:0] FN_OR   = 6'd37;
    localparam logic [5:0] FN_XOR  = 6'd38;
    localparam logic [5:0] FN_NOR  = 6'd39;
    localparam logic [5:0] FN_SLT  = 6'd42;
    localparam logic [5:0] FN_SLTU = 6'd43;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_SLT, K_SLTU, K_SLL, K_SRL, K_SRA, K_PASSB
    } alu_kind_e;

    typedef enum logic [1:0] {
        X_SIGN, X_ZERO, X_UPPER
    } ext_mode_e;

    typedef struct packed {
        alu_kind_e kind;
        ext_mode_e ext;
        logic      use_imm;
        logic      var_shift;
        logic      legal;
        logic      reg_form;
    } exu_ctl_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output exu_ctl_t   ctl_o
);

    exu_ctl_t ctl;

    always_comb begin
        ctl           = '0;
        ctl.kind      = K_NONE;
        ctl.ext       = X_SIGN;
        ctl.reg_form  = (opcode_i == OPC_REG);
        if (opcode_i == OPC_REG) begin
            ctl.legal = 1'b1;
            case (funct_i)
                FN_SLL:  ctl.kind = K_SLL;
                FN_SRL:  ctl.kind = K_SRL;
                FN_SRA:  ctl.kind = K_SRA;
                FN_SLLV: begin ctl.kind = K_SLL; ctl.var_shift = 1'b1; end
                FN_SRLV: begin ctl.kind = K_SRL; ctl.var_shift = 1'b1; end
                FN_SRAV: begin ctl.kind = K_SRA; ctl.var_shift = 1'b1; end
                FN_ADD, FN_ADDU: ctl.kind = K_ADD;
                FN_SUB, FN_SUBU: ctl.kind = K_SUB;
                FN_AND:  ctl.kind = K_AND;
                FN_OR:   ctl.kind = K_OR;
                FN_XOR:  ctl.kind = K_XOR;
                FN_NOR:  ctl.kind = K_NOR;
                FN_SLT:  ctl.kind = K_SLT;
                FN_SLTU: ctl.kind = K_SLTU;
                default: ctl.legal = 1'b0;
            endcase
        end else begin
            ctl.legal   = 1'b1;
            ctl.use_imm = 1'b1;
            case (opcode_i)
                OPC_ADDI:  begin ctl.kind = K_ADD;   ctl.ext = X_SIGN;  end
                OPC_ADDIU: begin ctl.kind = K_ADD;   ctl.ext = X_ZERO;  end
                OPC_SLTI:  begin ctl.kind = K_SLT;   ctl.ext = X_SIGN;  end
                OPC_SLTIU: begin ctl.kind = K_SLTU;  ctl.ext = X_ZERO;  end
                OPC_ANDI:  begin ctl.kind = K_AND;   ctl.ext = X_ZERO;  end
                OPC_ORI:   begin ctl.kind = K_OR;    ctl.ext = X_ZERO;  end
                OPC_XORI:  begin ctl.kind = K_XOR;   ctl.ext = X_ZERO;  end
                OPC_LUI:   begin ctl.kind = K_PASSB; ctl.ext = X_UPPER; end
                default: begin
                    ctl.legal   = 1'b0;
                    ctl.use_imm = 1'b0;
                end
            endcase
        end
        if (!ctl.legal) begin
            ctl.kind = K_NONE;
        end
    end

    assign ctl_o = ctl;

endmodule

// File: rtl/exu_immext.sv
module exu_immext
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic [IMMW-1:0] imm_i,
    input  ext_mode_e       mode_i,
    output logic [XLEN-1:0] ext_o
);

    localparam int PADW = XLEN - IMMW;

    always_comb begin
        case (mode_i)
            X_SIGN:  ext_o = {{PADW{imm_i[IMMW-1]}}, imm_i};
            X_ZERO:  ext_o = {{PADW{1'b0}}, imm_i};
            X_UPPER: ext_o = {imm_i, {PADW{1'b0}}};
            default: ext_o = '0;
        endcase
    end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [SHW-1:0]  amt_i,
    input  alu_kind_e       kind_i,
    output logic [XLEN-1:0] res_o
);

    logic              go_left;
    logic              fill;
    logic [XLEN-1:0]   val_rev;
    logic [XLEN-1:0]   src;
    logic [XLEN-1:0]   out_rev;
    logic [SHW:0][XLEN-1:0] stage;

    assign go_left = (kind_i == K_SLL);
    assign fill    = (kind_i == K_SRA) & val_i[XLEN-1];

    for (genvar b = 0; b < XLEN; b++) begin : g_rev_in
        assign val_rev[b] = val_i[XLEN-1-b];
    end

    assign src      = go_left ? val_rev : val_i;
    assign stage[0] = src;

    for (genvar g = 0; g < SHW; g++) begin : g_stage
        localparam int STEP = 1 << g;
        assign stage[g+1] = amt_i[g] ? {{STEP{fill}}, stage[g][XLEN-1:STEP]}
                                     : stage[g];
    end

    for (genvar b = 0; b < XLEN; b++) begin : g_rev_out
        assign out_rev[b] = stage[SHW][XLEN-1-b];
    end

    assign res_o = go_left ? out_rev : stage[SHW];

endmodule

// File: rtl/exu_int_alu.sv
module exu_int_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    parameter int RIDW = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [5:0]              opcode_i,
    input  logic [5:0]              funct_i,
    input  logic [$clog2(XLEN)-1:0] shamt_i,
    input  logic [XLEN-1:0]         rs_val_i,
    input  logic [XLEN-1:0]         rt_val_i,
    input  logic [IMMW-1:0]         imm_i,
    input  logic [RIDW-1:0]         rt_idx_i,
    input  logic [RIDW-1:0]         rd_idx_i,
    output logic [XLEN-1:0]         result_o,
    output logic                    wr_en_o,
    output logic [RIDW-1:0]         dest_o
);

    localparam int SHW = $clog2(XLEN);

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            wr_en;
        logic [RIDW-1:0] dest;
    } exu_out_t;

    exu_ctl_t        ctl;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] op_b;
    logic [SHW-1:0]  shift_amt;
    logic [XLEN-1:0] shift_res;
    logic            lt_signed;
    logic            lt_unsigned;
    exu_out_t        out_d;
    exu_out_t        out_q;

    exu_decode i_decode (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .ctl_o    (ctl)
    );

    exu_immext #(.XLEN(XLEN), .IMMW(IMMW)) i_immext (
        .imm_i  (imm_i),
        .mode_i (ctl.ext),
        .ext_o  (imm_ext)
    );

    assign op_b      = ctl.use_imm ? imm_ext : rt_val_i;
    assign shift_amt = ctl.var_shift ? rs_val_i[SHW-1:0] : shamt_i;

    exu_shifter #(.XLEN(XLEN), .SHW(SHW)) i_shifter (
        .val_i  (rt_val_i),
        .amt_i  (shift_amt),
        .kind_i (ctl.kind),
        .res_o  (shift_res)
    );

    assign lt_signed   = $signed(rs_val_i) < $signed(op_b);
    assign lt_unsigned = rs_val_i < op_b;

    always_comb begin
        out_d = '0;
        case (ctl.kind)
            K_ADD:   out_d.result = rs_val_i + op_b;
            K_SUB:   out_d.result = rs_val_i - op_b;
            K_AND:   out_d.result = rs_val_i & op_b;
            K_OR:    out_d.result = rs_val_i | op_b;
            K_XOR:   out_d.result = rs_val_i ^ op_b;
            K_NOR:   out_d.result = ~(rs_val_i | op_b);
            K_SLT:   out_d.result = {{(XLEN-1){1'b0}}, lt_signed};
            K_SLTU:  out_d.result = {{(XLEN-1){1'b0}}, lt_unsigned};
            K_SLL, K_SRL, K_SRA: out_d.result = shift_res;
            K_PASSB: out_d.result = op_b;
            default: out_d.result = '0;
        endcase
        if (ctl.legal) begin
            out_d.dest  = ctl.reg_form ? rd_idx_i : rt_idx_i;
            out_d.wr_en = (out_d.dest != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign wr_en_o  = out_q.wr_en;
    assign dest_o   = out_q.dest;

endmodule

// File: rtl/exu_int_alu_chk.sv
module exu_int_alu_chk #(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    parameter int RIDW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [5:0]      opcode_i,
    input logic [5:0]      funct_i,
    input logic [XLEN-1:0] rs_val_i,
    input logic [IMMW-1:0] imm_i,
    input logic [RIDW-1:0] rt_idx_i,
    input logic [RIDW-1:0] rd_idx_i,
    input logic [XLEN-1:0] result_o,
    input logic            wr_en_o
);

    // R4
    lui_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == 6'd15) |=> (result_o == {$past(imm_i), {(XLEN-IMMW){1'b0}}}));

    // R6
    slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode_i == 6'd10) || (opcode_i == 6'd11) ||
         ((opcode_i == 6'd0) && ((funct_i == 6'd42) || (funct_i == 6'd43))))
        |=> (result_o[XLEN-1:1] == '0));

    // R3
    andi_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == 6'd12) |=> (result_o[XLEN-1:IMMW] == '0));

    // R3
    ori_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == 6'd13) |=> (result_o[XLEN-1:IMMW] == $past(rs_val_i[XLEN-1:IMMW])));

    // R9
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((opcode_i == 6'd0) && (rd_idx_i == '0)) ||
         ((opcode_i != 6'd0) && (rt_idx_i == '0))) |=> !wr_en_o);

    // R10
    bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((opcode_i >= 6'd1) && (opcode_i <= 6'd7)) || (opcode_i > 6'd15))
        |=> (!wr_en_o && (result_o == '0)));

endmodule

bind exu_int_alu exu_int_alu_chk #(.XLEN(XLEN), .IMMW(IMMW), .RIDW(RIDW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .rs_val_i (rs_val_i),
    .imm_i    (imm_i),
    .rt_idx_i (rt_idx_i),
    .rd_idx_i (rd_idx_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/test_exu_int_alu.sv
module test_exu_int_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm = '0;
    logic [4:0]  rt_idx = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] result;
    logic        wr_en;
    logic [4:0]  dest;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    exu_int_alu i_exu_int_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (opcode),
        .funct_i  (funct),
        .shamt_i  (shamt),
        .rs_val_i (rs_val),
        .rt_val_i (rt_val),
        .imm_i    (imm),
        .rt_idx_i (rt_idx),
        .rd_idx_i (rd_idx),
        .result_o (result),
        .wr_en_o  (wr_en),
        .dest_o   (dest)
    );

    function automatic logic [31:0] pat(input int k);
        case (k & 7)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h1234_5678;
            6: return 32'hDEAD_BEEF;
            default: return 32'h0000_0025;
        endcase
    endfunction

    function automatic logic [15:0] ipat(input int k);
        case (k & 7)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'hFFFD;
            6: return 16'hABCD;
            default: return 16'h5678;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
        if (op == 0) begin
            case (fn)
                0, 2, 3: return "R7";
                4, 6, 7: return "R8";
                32, 33, 34, 35: return "R1";
                36, 37, 38, 39: return "R5";
                42, 43: return "R6";
                default: return "R10";
            endcase
        end
        case (op)
            8, 9: return "R2";
            10, 11: return "R6";
            12, 13, 14: return "R3";
            15: return "R4";
            default: return "R10";
        endcase
    endfunction

    // Spec model: returns {legal, value}
    function automatic logic [32:0] model(input logic [5:0] op, input logic [5:0] fn,
                                          input logic [4:0] sh, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] k);
        logic [31:0] sx = {{16{k[15]}}, k};
        logic [31:0] zx = {16'h0, k};
        if (op == 0) begin
            case (fn)
                0:  return {1'b1, b << sh};
                2:  return {1'b1, b >> sh};
                3:  return {1'b1, 32'($signed(b) >>> sh)};
                4:  return {1'b1, b << a[4:0]};
                6:  return {1'b1, b >> a[4:0]};
                7:  return {1'b1, 32'($signed(b) >>> a[4:0])};
                32, 33: return {1'b1, a + b};
                34, 35: return {1'b1, a - b};
                36: return {1'b1, a & b};
                37: return {1'b1, a | b};
                38: return {1'b1, a ^ b};
                39: return {1'b1, ~(a | b)};
                42: return {1'b1, 31'h0, $signed(a) < $signed(b)};
                43: return {1'b1, 31'h0, a < b};
                default: return 33'h0;
            endcase
        end
        case (op)
            8:  return {1'b1, a + sx};
            9:  return {1'b1, a + zx};
            10: return {1'b1, 31'h0, $signed(a) < $signed(sx)};
            11: return {1'b1, 31'h0, a < zx};
            12: return {1'b1, a & zx};
            13: return {1'b1, a | zx};
            14: return {1'b1, a ^ zx};
            15: return {1'b1, k, 16'h0};
            default: return 33'h0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sh,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] k,
                       input logic [4:0] rti, input logic [4:0] rdi);
        logic [32:0] m;
        logic [4:0]  ed;
        string       t;
        @(negedge clk);
        opcode = op; funct = fn; shamt = sh; rs_val = a; rt_val = b;
        imm = k; rt_idx = rti; rd_idx = rdi;
        @(posedge clk);
        #2;
        m  = model(op, fn, sh, a, b, k);
        ed = m[32] ? ((op == 0) ? rdi : rti) : 5'd0;
        t  = tag_of(op, fn);
        check(t, "result", result, m[31:0]);
        check("R9", "wr_en", {31'h0, wr_en}, {31'h0, m[32] && (ed != 0)});
        check("R9", "dest", {27'h0, dest}, {27'h0, ed});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] rfn [20] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7, 6'd32, 6'd33,
                                 6'd34, 6'd35, 6'd36, 6'd37, 6'd38, 6'd39, 6'd42,
                                 6'd43, 6'd1, 6'd5, 6'd40, 6'd63};
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        check("R11", "reset result", result, 32'h0);
        check("R11", "reset wr_en", {31'h0, wr_en}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 one-cycle latency: output unchanged before the edge
        run(6'd0, 6'd32, 5'd0, 32'd5, 32'd7, 16'h0, 5'd2, 5'd3);
        @(negedge clk);
        opcode = 6'd0; funct = 6'd34; rs_val = 32'd100; rt_val = 32'd1; rd_idx = 5'd4;
        #1;
        check("R11", "latency hold", result, 32'd12);
        @(posedge clk);
        #2;
        check("R11", "latency update", result, 32'd99);

        // Register-register sweep (R1 R5 R6 R7 R8 R10)
        for (int f = 0; f < 20; f++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(6'd0, rfn[f], 5'((i * 5 + j * 3) & 31), pat(i), pat(j), 16'h0,
                        5'd9, 5'(1 + ((i + j) & 15)));

        // Every shift distance, both sources (R7 R8)
        for (int s = 0; s < 32; s++) begin
            run(6'd0, 6'd0, 5'(s), 32'h0, 32'hDEAD_BEEF, 16'h0, 5'd1, 5'd1);
            run(6'd0, 6'd2, 5'(s), 32'h0, 32'h8000_0001, 16'h0, 5'd1, 5'd1);
            run(6'd0, 6'd3, 5'(s), 32'h0, 32'h8000_0001, 16'h0, 5'd1, 5'd1);
            run(6'd0, 6'd4, 5'd0, 32'hFFFF_FFE0 | 32'(s), 32'hDEAD_BEEF, 16'h0, 5'd1, 5'd1);
            run(6'd0, 6'd6, 5'd0, 32'hFFFF_FFE0 | 32'(s), 32'h8000_0001, 16'h0, 5'd1, 5'd1);
            run(6'd0, 6'd7, 5'd0, 32'hFFFF_FFE0 | 32'(s), 32'h8000_0001, 16'h0, 5'd1, 5'd1);
        end

        // Immediate sweep (R2 R3 R4 R6)
        for (int op = 8; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int k = 0; k < 8; k++)
                    run(6'(op), 6'(k * 7), 5'd0, pat(i), 32'hCAFE_F00D, ipat(k),
                        5'(1 + i + k), 5'd0);

        // Unsupported opcodes (R10)
        for (int op = 1; op < 64; op++)
            if (op < 8 || op > 15)
                run(6'(op), 6'd32, 5'd0, 32'd3, 32'd4, 16'h1234, 5'd7, 5'd8);

        // Destination selection and register 0 (R9)
        for (int d = 0; d < 32; d++) begin
            run(6'd0, 6'd33, 5'd0, 32'd1, 32'd2, 16'h0, 5'(31 - d), 5'(d));
            run(6'd8, 6'd0, 5'd0, 32'd1, 32'd0, 16'hFFFD, 5'(d), 5'(31 - d));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule